// File: doc/BRIEF.md
# Time-Slotted DMA Network Interface

This block connects one processor node to a message-passing network whose link use is fixed by a repeating time-slot plan. Each slot is three clock cycles long. A small slot table says which logical push channel, if any, owns each slot. One DMA engine is shared by every channel; it keeps the progress of each channel (local read pointer, remote write pointer, words left, destination route) in a per-channel table. When a channel's slot comes round and that channel still has words to send, the engine reads two consecutive words from the local scratchpad and emits one packet carrying the route, the remote word address and the two payload words, then moves the channel's pointers on by two.

Software fills the slot table once before traffic starts, then starts a transfer by writing one setup command with the channel, local start address, remote start address, route and length in words. The transfer then runs to its end with no further processor action; a per-channel idle flag tells software when the words are all sent. In the other direction, every packet that arrives is written straight into the scratchpad at the address it carries, one cycle later, in arrival order, with no completion indication. There is no flow control and no buffering: the schedule itself guarantees link capacity.

Top module: `tdm_ni`

## Requirements
- R1: While reset is held and in the first cycle after it, `pktValid` is 0, `spmWrEn` is 2'b00, `spmRdEn` is 0 and every bit of `chanIdle` is 1; every slot-table entry is disabled.
- R2: The slot index starts at 0 after reset, lasts 3 cycles and wraps from NUM_SLOTS-1 to 0. A packet is emitted only in the first cycle of slot s+1 (mod NUM_SLOTS) when slot s is enabled and its channel had a non-zero remaining length in the first cycle of slot s; at most one packet per slot, so `pktValid` is never high in two of any three consecutive cycles.
- R3: An emitted packet carries the channel's route on `pktRoute`, its remote pointer on `pktAddr`, the scratchpad word at its local pointer on `pktData0` and the word at local pointer + 1 on `pktData1`, with `pktWe` = 2'b11 when at least two words remained.
- R4: After each packet the channel's local and remote pointers both advance by 2 (modulo the address width) and its remaining length drops by 2, so the packets of one transfer cover consecutive word pairs in order.
- R5: `chanIdle[c]` is 1 exactly when channel c has zero words remaining; a started transfer runs to zero with no further processor writes.
- R6: A setup with length 0 leaves the channel idle and produces no packet and no scratchpad read for it.
- R7: When exactly one word remains, the packet has `pktWe` = 2'b01 and `pktData1` = 0, the second scratchpad read of that slot is not issued, and the length becomes 0.
- R8: A packet presented on `rxValid` is written to the scratchpad in the next cycle: `spmWrEn` equals `rxWe` (bit 0 for the word at `rxAddr`, bit 1 for `rxAddr`+1), `spmWrAddr` equals `rxAddr`, data words unchanged; with no arriving packet `spmWrEn` is 2'b00.
- R9: A setup write to a channel during any cycle of a slot in which that channel is being served (including the cycle the engine would update the entry) wins: the entry holds the written values and the engine's update for that slot is dropped; the packet of that slot still goes out with the old values.
- R10: In a served slot the engine reads the scratchpad in the first cycle at the local pointer and in the second cycle at the local pointer + 1 (unless R7 applies), with read data expected one cycle after the address; no read occurs in the third cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| schedWe | input | 1 | Write one slot-table entry |
| schedSlot | input | SLOT_W | Slot index written |
| schedChan | input | CH_W | Channel that owns the slot |
| schedEn | input | 1 | Slot enabled (1) or unused (0) |
| setupValid | input | 1 | Start (or overwrite) a channel transfer |
| setupChan | input | CH_W | Channel being set up |
| setupLocal | input | AW | Local scratchpad start word address |
| setupRemote | input | AW | Remote scratchpad start word address |
| setupRoute | input | ROUTE_W | Destination route for the channel |
| setupLen | input | LEN_W | Transfer length in words |
| chanIdle | output | NUM_CHAN | Per-channel idle (no words left) |
| spmRdEn | output | 1 | Scratchpad read strobe |
| spmRdAddr | output | AW | Scratchpad read word address |
| spmRdData | input | DW | Scratchpad read data, one cycle after the address |
| spmWrEn | output | 2 | Scratchpad write enable per word |
| spmWrAddr | output | AW | Scratchpad write address of the first word |
| spmWrData0 | output | DW | Word written at `spmWrAddr` |
| spmWrData1 | output | DW | Word written at `spmWrAddr`+1 |
| pktValid | output | 1 | Outgoing packet present this cycle |
| pktRoute | output | ROUTE_W | Route of the outgoing packet |
| pktAddr | output | AW | Remote word address of the outgoing packet |
| pktWe | output | 2 | Word enables of the outgoing packet |
| pktData0 | output | DW | First payload word |
| pktData1 | output | DW | Second payload word |
| rxValid | input | 1 | Incoming packet present |
| rxAddr | input | AW | Local word address of the incoming packet |
| rxWe | input | 2 | Word enables of the incoming packet |
| rxData0 | input | DW | First incoming word |
| rxData1 | input | DW | Second incoming word |

## Verification
A wrong slot counter or slot table shows as a packet in the wrong cycle or a read strobe in a slot that should be silent, visible within one slot period of 30 cycles at the default size. A corrupted channel entry shows as a wrong `pktAddr` or payload on that channel's next packet, and a wrong remaining length shows on `chanIdle` at once, and as a packet too many or too few by the end of the transfer. A lost priority between processor write and engine update shows on the first packet after the overwrite, whose address and data must come from the newly written pointers.

// File: rtl/tdm_ni_pkg.sv
package tdm_ni_pkg;

  // Cycles in one time slot; the engine's three steps map onto them.
  localparam int SLOT_CYCLES = 3;

  // Strobes from the slot control to the DMA datapath.
  typedef struct packed {
    logic rd0;   // first cycle of a served slot: read first word
    logic rd1;   // second cycle: read second word, capture first
    logic emit;  // third cycle: form packet, update table entry
  } engStrobe_t;

endpackage

// File: rtl/tdm_ni_ctrl.sv
module tdm_ni_ctrl
  import tdm_ni_pkg::*;
#(
  parameter  int NUM_CHAN  = 4,
  parameter  int NUM_SLOTS = 10,
  localparam int CH_W      = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int PH_W      = $clog2(SLOT_CYCLES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                schedWe,
  input  logic [SLOT_W-1:0]   schedSlot,
  input  logic [CH_W-1:0]     schedChan,
  input  logic                schedEn,
  input  logic [NUM_CHAN-1:0] chanIdle,
  output engStrobe_t          strobe,
  output logic [CH_W-1:0]     curChan
);

  logic [PH_W-1:0]   phase;
  logic [SLOT_W-1:0] slotIdx;

  logic [NUM_SLOTS-1:0]           schedOn;
  logic [NUM_SLOTS-1:0][CH_W-1:0] schedOwner;

  logic              fireQ;
  logic [CH_W-1:0]   chanQ;
  logic [CH_W-1:0]   lookupChan;
  logic              lookupOn;
  logic              startNow;

  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(SLOT_CYCLES - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  // Slot timing: phase counts within a slot, slotIdx walks the period.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      slotIdx <= '0;
    end else if (phase == PH_LAST) begin
      phase   <= '0;
      slotIdx <= (slotIdx == SLOT_LAST) ? '0 : slotIdx + SLOT_W'(1);
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  // Slot ownership table, written by software before traffic starts.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      schedOn    <= '0;
      schedOwner <= '0;
    end else if (schedWe) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (schedSlot == SLOT_W'(s)) begin
          schedOn[s]    <= schedEn;
          schedOwner[s] <= schedChan;
        end
      end
    end
  end

  assign lookupOn   = schedOn[slotIdx];
  assign lookupChan = schedOwner[slotIdx];
  assign startNow   = (phase == '0) && lookupOn && !chanIdle[lookupChan];

  // Latch the decision for the remaining cycles of the slot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fireQ <= 1'b0;
      chanQ <= '0;
    end else if (phase == '0) begin
      fireQ <= startNow;
      chanQ <= lookupChan;
    end
  end

  assign strobe.rd0  = startNow;
  assign strobe.rd1  = (phase == PH_W'(1)) && fireQ;
  assign strobe.emit = (phase == PH_LAST) && fireQ;
  assign curChan     = (phase == '0) ? lookupChan : chanQ;

endmodule

// File: rtl/tdm_ni_dp.sv
module tdm_ni_dp
  import tdm_ni_pkg::*;
#(
  parameter  int NUM_CHAN = 4,
  parameter  int AW       = 10,
  parameter  int DW       = 32,
  parameter  int ROUTE_W  = 8,
  parameter  int LEN_W    = 10,
  localparam int CH_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  engStrobe_t          strobe,
  input  logic [CH_W-1:0]     curChan,
  input  logic                setupValid,
  input  logic [CH_W-1:0]     setupChan,
  input  logic [AW-1:0]       setupLocal,
  input  logic [AW-1:0]       setupRemote,
  input  logic [ROUTE_W-1:0]  setupRoute,
  input  logic [LEN_W-1:0]    setupLen,
  output logic [NUM_CHAN-1:0] chanIdle,
  output logic                spmRdEn,
  output logic [AW-1:0]       spmRdAddr,
  input  logic [DW-1:0]       spmRdData,
  output logic [1:0]          spmWrEn,
  output logic [AW-1:0]       spmWrAddr,
  output logic [DW-1:0]       spmWrData0,
  output logic [DW-1:0]       spmWrData1,
  output logic                pktValid,
  output logic [ROUTE_W-1:0]  pktRoute,
  output logic [AW-1:0]       pktAddr,
  output logic [1:0]          pktWe,
  output logic [DW-1:0]       pktData0,
  output logic [DW-1:0]       pktData1,
  input  logic                rxValid,
  input  logic [AW-1:0]       rxAddr,
  input  logic [1:0]          rxWe,
  input  logic [DW-1:0]       rxData0,
  input  logic [DW-1:0]       rxData1
);

  // Per-channel progress table.
  logic [AW-1:0]      tLocal  [NUM_CHAN];
  logic [AW-1:0]      tRemote [NUM_CHAN];
  logic [ROUTE_W-1:0] tRoute  [NUM_CHAN];
  logic [LEN_W-1:0]   tCount  [NUM_CHAN];

  // Snapshot of the served entry, taken in the first cycle of the slot.
  logic [AW-1:0]      snapLocal;
  logic [AW-1:0]      snapRemote;
  logic [ROUTE_W-1:0] snapRoute;
  logic               snapOdd;
  logic               dirty;
  logic [DW-1:0]      word0;
  logic               setupHitCur;

  assign setupHitCur = setupValid && (setupChan == curChan);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snapLocal  <= '0;
      snapRemote <= '0;
      snapRoute  <= '0;
      snapOdd    <= 1'b0;
      dirty      <= 1'b0;
      word0      <= '0;
    end else begin
      if (strobe.rd0) begin
        snapLocal  <= tLocal[curChan];
        snapRemote <= tRemote[curChan];
        snapRoute  <= tRoute[curChan];
        snapOdd    <= (tCount[curChan] == LEN_W'(1));
        dirty      <= setupHitCur;
      end else if (setupHitCur) begin
        dirty <= 1'b1;
      end
      if (strobe.rd1) begin
        word0 <= spmRdData;
      end
    end
  end

  // Table writes: a processor setup always beats the engine update.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CHAN; c++) begin
        tLocal[c]  <= '0;
        tRemote[c] <= '0;
        tRoute[c]  <= '0;
        tCount[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CHAN; c++) begin
        if (setupValid && setupChan == CH_W'(c)) begin
          tLocal[c]  <= setupLocal;
          tRemote[c] <= setupRemote;
          tRoute[c]  <= setupRoute;
          tCount[c]  <= setupLen;
        end else if (strobe.emit && !dirty && curChan == CH_W'(c)) begin
          tLocal[c]  <= snapLocal + AW'(2);
          tRemote[c] <= snapRemote + AW'(2);
          tCount[c]  <= snapOdd ? '0 : tCount[c] - LEN_W'(2);
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_idle
    assign chanIdle[c] = (tCount[c] == '0);
  end

  // Scratchpad read port: first word in cycle 0, second in cycle 1.
  assign spmRdEn   = strobe.rd0 || (strobe.rd1 && !snapOdd);
  assign spmRdAddr = strobe.rd0 ? tLocal[curChan] : snapLocal + AW'(1);

  // Outgoing packet register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pktValid <= 1'b0;
      pktRoute <= '0;
      pktAddr  <= '0;
      pktWe    <= '0;
      pktData0 <= '0;
      pktData1 <= '0;
    end else begin
      pktValid <= strobe.emit;
      if (strobe.emit) begin
        pktRoute <= snapRoute;
        pktAddr  <= snapRemote;
        pktWe    <= snapOdd ? 2'b01 : 2'b11;
        pktData0 <= word0;
        pktData1 <= snapOdd ? '0 : spmRdData;
      end
    end
  end

  // Receive path: one register stage straight into the scratchpad.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spmWrEn    <= '0;
      spmWrAddr  <= '0;
      spmWrData0 <= '0;
      spmWrData1 <= '0;
    end else begin
      spmWrEn <= rxValid ? rxWe : 2'b00;
      if (rxValid) begin
        spmWrAddr  <= rxAddr;
        spmWrData0 <= rxData0;
        spmWrData1 <= rxData1;
      end
    end
  end

endmodule

// File: rtl/tdm_ni.sv
module tdm_ni
  import tdm_ni_pkg::*;
#(
  parameter  int NUM_CHAN  = 4,
  parameter  int NUM_SLOTS = 10,
  parameter  int AW        = 10,
  parameter  int DW        = 32,
  parameter  int ROUTE_W   = 8,
  parameter  int LEN_W     = 10,
  localparam int CH_W      = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                schedWe,
  input  logic [SLOT_W-1:0]   schedSlot,
  input  logic [CH_W-1:0]     schedChan,
  input  logic                schedEn,
  input  logic                setupValid,
  input  logic [CH_W-1:0]     setupChan,
  input  logic [AW-1:0]       setupLocal,
  input  logic [AW-1:0]       setupRemote,
  input  logic [ROUTE_W-1:0]  setupRoute,
  input  logic [LEN_W-1:0]    setupLen,
  output logic [NUM_CHAN-1:0] chanIdle,
  output logic                spmRdEn,
  output logic [AW-1:0]       spmRdAddr,
  input  logic [DW-1:0]       spmRdData,
  output logic [1:0]          spmWrEn,
  output logic [AW-1:0]       spmWrAddr,
  output logic [DW-1:0]       spmWrData0,
  output logic [DW-1:0]       spmWrData1,
  output logic                pktValid,
  output logic [ROUTE_W-1:0]  pktRoute,
  output logic [AW-1:0]       pktAddr,
  output logic [1:0]          pktWe,
  output logic [DW-1:0]       pktData0,
  output logic [DW-1:0]       pktData1,
  input  logic                rxValid,
  input  logic [AW-1:0]       rxAddr,
  input  logic [1:0]          rxWe,
  input  logic [DW-1:0]       rxData0,
  input  logic [DW-1:0]       rxData1
);

  engStrobe_t      strobe;
  logic [CH_W-1:0] curChan;

  tdm_ni_ctrl #(
    .NUM_CHAN (NUM_CHAN),
    .NUM_SLOTS(NUM_SLOTS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .schedWe  (schedWe),
    .schedSlot(schedSlot),
    .schedChan(schedChan),
    .schedEn  (schedEn),
    .chanIdle (chanIdle),
    .strobe   (strobe),
    .curChan  (curChan)
  );

  tdm_ni_dp #(
    .NUM_CHAN(NUM_CHAN),
    .AW      (AW),
    .DW      (DW),
    .ROUTE_W (ROUTE_W),
    .LEN_W   (LEN_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .curChan    (curChan),
    .setupValid (setupValid),
    .setupChan  (setupChan),
    .setupLocal (setupLocal),
    .setupRemote(setupRemote),
    .setupRoute (setupRoute),
    .setupLen   (setupLen),
    .chanIdle   (chanIdle),
    .spmRdEn    (spmRdEn),
    .spmRdAddr  (spmRdAddr),
    .spmRdData  (spmRdData),
    .spmWrEn    (spmWrEn),
    .spmWrAddr  (spmWrAddr),
    .spmWrData0 (spmWrData0),
    .spmWrData1 (spmWrData1),
    .pktValid   (pktValid),
    .pktRoute   (pktRoute),
    .pktAddr    (pktAddr),
    .pktWe      (pktWe),
    .pktData0   (pktData0),
    .pktData1   (pktData1),
    .rxValid    (rxValid),
    .rxAddr     (rxAddr),
    .rxWe       (rxWe),
    .rxData0    (rxData0),
    .rxData1    (rxData1)
  );

endmodule

// File: rtl/tdm_ni_chk.sv
module tdm_ni_chk #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spmRdEn,
  input logic [AW-1:0] spmRdAddr,
  input logic [1:0]    spmWrEn,
  input logic [AW-1:0] spmWrAddr,
  input logic [DW-1:0] spmWrData0,
  input logic          pktValid,
  input logic [1:0]    pktWe,
  input logic [DW-1:0] pktData1,
  input logic          rxValid,
  input logic [AW-1:0] rxAddr,
  input logic [1:0]    rxWe,
  input logic [DW-1:0] rxData0
);

  // R2: at most one packet per three-cycle slot
  a_r2_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid |=> !pktValid ##1 !pktValid);

  // R2: a packet follows the first read of its slot by exactly three cycles
  a_r2_pkt_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid |-> $past(spmRdEn, 3));

  // R10: back-to-back reads address consecutive words
  a_r10_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (spmRdEn && $past(spmRdEn)) |-> spmRdAddr == $past(spmRdAddr) + AW'(1));

  // R10: never a read in the third cycle of a slot
  a_r10_no_third_read: assert property (@(posedge clk) disable iff (!rst_n)
    (spmRdEn && $past(spmRdEn)) |=> !spmRdEn);

  // R7: a padded packet carries a zero second word
  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pktValid && pktWe == 2'b01) |-> pktData1 == '0);

  // R3: every packet enables its first word
  a_r3_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid |-> pktWe[0]);

  // R8: an arriving packet is written on the next cycle
  a_r8_rx_write: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> (spmWrEn == $past(rxWe) && spmWrAddr == $past(rxAddr)
                 && spmWrData0 == $past(rxData0)));

  // R8: no write without an arriving packet
  a_r8_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rxValid |=> spmWrEn == 2'b00);

endmodule

bind tdm_ni tdm_ni_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spmRdEn   (spmRdEn),
  .spmRdAddr (spmRdAddr),
  .spmWrEn   (spmWrEn),
  .spmWrAddr (spmWrAddr),
  .spmWrData0(spmWrData0),
  .pktValid  (pktValid),
  .pktWe     (pktWe),
  .pktData1  (pktData1),
  .rxValid   (rxValid),
  .rxAddr    (rxAddr),
  .rxWe      (rxWe),
  .rxData0   (rxData0)
);

// File: tb/tdm_ni_bench.sv
`timescale 1ns/1ps
module tdm_ni_bench;

  localparam int NCH = 4;
  localparam int NSL = 10;
  localparam int AW  = 10;
  localparam int DW  = 32;
  localparam int PERIOD = 3 * NSL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          schedWe = 0;
  logic [3:0]    schedSlot = 0;
  logic [1:0]    schedChan = 0;
  logic          schedEn = 0;
  logic          setupValid = 0;
  logic [1:0]    setupChan = 0;
  logic [AW-1:0] setupLocal = 0;
  logic [AW-1:0] setupRemote = 0;
  logic [7:0]    setupRoute = 0;
  logic [9:0]    setupLen = 0;
  logic [NCH-1:0] chanIdle;
  logic          spmRdEn;
  logic [AW-1:0] spmRdAddr;
  logic [DW-1:0] spmRdData = 0;
  logic [1:0]    spmWrEn;
  logic [AW-1:0] spmWrAddr;
  logic [DW-1:0] spmWrData0, spmWrData1;
  logic          pktValid;
  logic [7:0]    pktRoute;
  logic [AW-1:0] pktAddr;
  logic [1:0]    pktWe;
  logic [DW-1:0] pktData0, pktData1;
  logic          rxValid = 0;
  logic [AW-1:0] rxAddr = 0;
  logic [1:0]    rxWe = 0;
  logic [DW-1:0] rxData0 = 0, rxData1 = 0;

  always #4 clk = ~clk;  // 125 MHz

  tdm_ni u_tdm_ni (.*);

  // Scratchpad model
  logic [DW-1:0] mem [1 << AW];
  always @(posedge clk) begin
    if (spmRdEn) spmRdData <= mem[spmRdAddr];
    if (spmWrEn[0]) mem[spmWrAddr] <= spmWrData0;
    if (spmWrEn[1]) mem[spmWrAddr + AW'(1)] <= spmWrData1;
  end

  function automatic logic [DW-1:0] srcVal(input int a);
    return 32'hC0DE0000 ^ (a * 32'h00010003);
  endfunction

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model state
  int mCyc;
  bit mSchedV [NSL];
  int mSchedC [NSL];
  int mLocal [NCH], mRemote [NCH], mRoute [NCH], mCount [NCH];
  bit mFire, mOdd, mDirty;
  int mChan, mSnapLocal, mSnapRemote, mSnapRoute;
  bit eValid; int eRoute, eAddr, eWe; logic [DW-1:0] eD0, eD1;
  int eWrEn, eWrAddr; logic [DW-1:0] eWd0, eWd1;
  int pktCount [256];
  bit watch9 = 0, watch11 = 0;
  int r2Bad = 0;

  task automatic modelReset();
    mCyc = 0; mFire = 0; mOdd = 0; mDirty = 0; mChan = 0;
    mSnapLocal = 0; mSnapRemote = 0; mSnapRoute = 0;
    for (int s = 0; s < NSL; s++) begin mSchedV[s] = 0; mSchedC[s] = 0; end
    for (int c = 0; c < NCH; c++) begin
      mLocal[c] = 0; mRemote[c] = 0; mRoute[c] = 0; mCount[c] = 0;
    end
    eValid = 0; eWrEn = 0;
  endtask

  task automatic checkOutputs();
    int p, s, ch;
    bit rdE; int rdA;
    logic [NCH-1:0] idleE;
    p = mCyc % 3; s = (mCyc / 3) % NSL;
    rdE = 0; rdA = 0;
    if (p == 0) begin
      ch = mSchedC[s];
      rdE = mSchedV[s] && mCount[ch] != 0; rdA = mLocal[ch];
    end else if (p == 1) begin
      rdE = mFire && !mOdd; rdA = (mSnapLocal + 1) % (1 << AW);
    end
    chk("R10", "spmRdEn", spmRdEn, rdE);
    if (rdE) chk("R10", "spmRdAddr", spmRdAddr, rdA);
    chk("R2", "pktValid", pktValid, eValid);
    if (eValid && pktValid) begin
      chk("R3", "pktRoute", pktRoute, eRoute);
      chk("R4", "pktAddr", pktAddr, eAddr);
      chk(eWe == 1 ? "R7" : "R3", "pktWe", pktWe, eWe);
      chk("R3", "pktData0", pktData0, eD0);
      chk(eWe == 1 ? "R7" : "R3", "pktData1", pktData1, eD1);
    end
    for (int c = 0; c < NCH; c++) idleE[c] = (mCount[c] == 0);
    chk("R5", "chanIdle", chanIdle, idleE);
    chk("R8", "spmWrEn", spmWrEn, eWrEn);
    if (eWrEn != 0) begin
      chk("R8", "spmWrAddr", spmWrAddr, eWrAddr);
      chk("R8", "spmWrData", {spmWrData1, spmWrData0}, {eWd1, eWd0});
    end
    if (pktValid) begin
      pktCount[pktRoute]++;
      if (pktRoute == 1 && (mCyc % PERIOD) != 3 && (mCyc % PERIOD) != 0) r2Bad++;
      if (pktRoute == 9 && !watch9) begin
        watch9 = 1;
        chk("R9", "first packet after overwrite addr", pktAddr, 200);
        chk("R9", "first packet after overwrite data", pktData0, srcVal(120));
      end
      if (pktRoute == 11 && !watch11) begin
        watch11 = 1;
        chk("R9", "first packet after mid-slot overwrite addr", pktAddr, 400);
      end
    end
  endtask

  task automatic modelStep();
    int p, s;
    bit hit;
    p = mCyc % 3; s = (mCyc / 3) % NSL;
    eValid = 0;
    if (p == 0) begin
      mChan = mSchedC[s];
      mFire = mSchedV[s] && mCount[mChan] != 0;
      mSnapLocal = mLocal[mChan]; mSnapRemote = mRemote[mChan];
      mSnapRoute = mRoute[mChan]; mOdd = (mCount[mChan] == 1); mDirty = 0;
    end
    hit = setupValid && (int'(setupChan) == mChan);
    if (hit) mDirty = 1;
    if (p == 2 && mFire) begin
      eValid = 1; eRoute = mSnapRoute; eAddr = mSnapRemote;
      eWe = mOdd ? 1 : 3;
      eD0 = srcVal(mSnapLocal);
      eD1 = mOdd ? '0 : srcVal((mSnapLocal + 1) % (1 << AW));
      if (!mDirty) begin
        mLocal[mChan]  = (mSnapLocal + 2) % (1 << AW);
        mRemote[mChan] = (mSnapRemote + 2) % (1 << AW);
        mCount[mChan]  = mOdd ? 0 : mCount[mChan] - 2;
      end
    end
    if (setupValid) begin
      mLocal[setupChan] = setupLocal; mRemote[setupChan] = setupRemote;
      mRoute[setupChan] = setupRoute; mCount[setupChan] = setupLen;
    end
    if (schedWe) begin
      mSchedV[schedSlot] = schedEn; mSchedC[schedSlot] = schedChan;
    end
    eWrEn = rxValid ? rxWe : 0;
    eWrAddr = rxAddr; eWd0 = rxData0; eWd1 = rxData1;
    mCyc++;
  endtask

  // Called at a negedge with inputs set; returns at the next negedge.
  task automatic tick();
    checkOutputs();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    schedWe = 0; setupValid = 0; rxValid = 0;
  endtask

  task automatic setup(input int ch, input int loc, input int rem, input int route, input int len);
    setupValid = 1; setupChan = 2'(ch); setupLocal = AW'(loc);
    setupRemote = AW'(rem); setupRoute = 8'(route); setupLen = 10'(len);
  endtask

  int rxK = 0;
  logic [DW-1:0] rxExp [1 << AW];
  bit rxHas [1 << AW];

  task automatic maybeRx(input int i);
    if (i % 17 == 5 && rxK < 12) begin
      rxValid = 1; rxAddr = AW'(512 + 4 * rxK);
      rxWe = (rxK % 3 == 0) ? 2'b11 : (rxK % 3 == 1) ? 2'b01 : 2'b10;
      rxData0 = 32'hAB000000 + rxK; rxData1 = 32'hCD000000 + rxK;
      if (rxWe[0]) begin rxExp[512 + 4 * rxK] = rxData0; rxHas[512 + 4 * rxK] = 1; end
      if (rxWe[1]) begin rxExp[513 + 4 * rxK] = rxData1; rxHas[513 + 4 * rxK] = 1; end
      rxK++;
    end
  endtask

  initial begin : watchdog
    int n;
    n = 0;
    while (!done) begin
      @(posedge clk);
      n++;
      if (n > 150000) begin
        checks++; failures++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", n, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : main
    int sl [5];
    int cl [5];
    for (int a = 0; a < (1 << AW); a++) begin
      mem[a] = (a < 256) ? srcVal(a) : '0;
      rxHas[a] = 0; rxExp[a] = '0;
    end
    for (int r = 0; r < 256; r++) pktCount[r] = 0;
    modelReset();

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "pktValid in reset", pktValid, 0);
    chk("R1", "chanIdle in reset", chanIdle, 4'hF);
    chk("R1", "spmWrEn in reset", spmWrEn, 0);
    chk("R1", "spmRdEn in reset", spmRdEn, 0);
    rst_n = 1;

    // Slot plan: slot0->ch0, slot2->ch1, slot5->ch2, slot7->ch3, slot9->ch0
    sl = '{0, 2, 5, 7, 9}; cl = '{0, 1, 2, 3, 0};
    for (int k = 0; k < 5; k++) begin
      schedWe = 1; schedSlot = 4'(sl[k]); schedChan = 2'(cl[k]); schedEn = 1;
      tick();
    end
    repeat (40) tick();  // plan loaded, nothing active: no packets (R2)

    setup(0, 0, 100, 1, 6); tick();
    setup(1, 40, 600, 2, 5); tick();
    setup(2, 60, 700, 3, 0); tick();
    chk("R6", "zero-length channel idle", chanIdle[2], 1);
    setup(3, 80, 300, 4, 20); tick();

    // wait for ch3's second service, overwrite in its update cycle (R9)
    begin
      int seen3 = 0;
      int i = 0;
      while (i < 2000) begin
        if ((mCyc % PERIOD) == 23 && mFire && mChan == 3) begin
          seen3++;
          if (seen3 == 2) break;
        end
        maybeRx(i); tick(); i++;
      end
    end
    setup(3, 120, 200, 9, 4); tick();

    for (int i = 0; i < 200; i++) begin maybeRx(i + 300); tick(); end

    // ch0 again, overwritten during the second cycle of a served slot (R9)
    setup(0, 160, 800, 10, 8); tick();
    for (int i = 0; i < 2000; i++) begin
      if ((mCyc % 3) == 1 && mFire && mChan == 0) break;
      tick();
    end
    setup(0, 200, 400, 11, 3); tick();

    for (int i = 0; i < 400; i++) begin maybeRx(i + 600); tick(); end
    repeat (3) tick();

    chk("R4", "packets for 6-word transfer", pktCount[1], 3);
    chk("R7", "packets for 5-word transfer", pktCount[2], 3);
    chk("R6", "packets for zero-length channel", pktCount[3], 0);
    chk("R9", "packets after in-update overwrite", pktCount[9], 2);
    chk("R7", "packets for 3-word transfer", pktCount[11], 2);
    chk("R9", "overwritten slot still emitted", pktCount[10] >= 1, 1);
    chk("R2", "ch0 packets outside its slots", r2Bad, 0);
    chk("R5", "all channels idle at end", chanIdle, 4'hF);
    chk("R8", "rx packets sent", rxK, 12);
    for (int a = 512; a < 512 + 4 * 12; a++) begin
      chk("R8", $sformatf("scratchpad word %0d", a), mem[a], rxHas[a] ? rxExp[a] : '0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule